// File: doc/BRIEF.md
# Thermal Printhead Line Controller

This block prints one line on a thermal print head. A start command opens a line. The block then asks for the line's dot data as a stream of words over a valid/ready handshake. It sends the dots out one at a time on a serial data line, with a companion serial clock. When the last dot is out, it pulses a latch so the head takes over the shifted pattern. After that it heats the head in four strobe phases, one after another.

Each strobe phase stays on for a programmable number of timebase ticks. A programmable idle gap follows each phase except the last. A polarity input chooses whether the strobe lines are active-high or active-low.

Lines are paced by a fixed line period. A start command that comes early waits until the period ends. The next line may be shifted while the previous line is still heating. Its latch pulse waits until the previous line's last strobe has dropped. A one-cycle done flag marks the end of the last strobe.

Top module: `tph_line_ctrl`

## Requirements
- R1: After reset, all four strobe lines are at their inactive level (low when `stb_pol_i`=1), and the latch, serial clock, done flag and `ready_o` are low.
- R2: `ready_o` is high only while a line is asking for data. It asks for DOTS/WORD_W words, one per handshake. `valid_i` and `data_i` have no effect while `ready_o` is low.
- R3: Each word is sent most-significant bit first, and words go out in the order they were accepted. There is exactly one rising edge of `sclk_o` per dot. `sdata_o` changes only while `sclk_o` is low, so it is stable at every rising edge.
- R4: Once the last dot has been clocked, one latch pulse of LATCH_W cycles is issued. No strobe is active during the pulse, and strobe 0 rises only after the pulse ends.
- R5: Strobes fire in the fixed order 0, 1, 2, 3 (bit index of `stb_o`), and at most one is active at any time.
- R6: Each strobe is active for max(`on_width_i`,1) × TICK_DIV clock cycles. An on-width of 0 is treated as 1 tick.
- R7: Between strobe n and strobe n+1 there are `off_gap_i` × TICK_DIV idle cycles. A gap of 0 makes the next strobe rise in the same cycle the previous one falls. No gap follows strobe 3.
- R8: With `stb_pol_i`=1 the strobes are active-high. With `stb_pol_i`=0 they are active-low, so they sit at 1 when idle.
- R9: Two line launches are at least LINE_TICKS × TICK_DIV cycles apart. A start that comes early is held, and the line launches exactly at the period boundary; the first `ready_o` of the two lines is then exactly that many cycles apart.
- R10: A new line may be shifted while the previous line's strobes are firing. Its latch pulse begins only after strobe 3 of the previous line has deasserted.
- R11: `line_done_o` is high for exactly one cycle, in the cycle in which strobe 3 deasserts.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| start_i | input | 1 | Start-line command, one cycle |
| data_i | input | WORD_W | Dot data word, MSB sent first |
| valid_i | input | 1 | Data word valid |
| ready_o | output | 1 | Block accepts a data word |
| stb_pol_i | input | 1 | 1: strobes active-high, 0: active-low |
| on_width_i | input | CNT_W | Strobe on-time in ticks |
| off_gap_i | input | CNT_W | Idle gap between strobes in ticks |
| sdata_o | output | 1 | Serial dot data |
| sclk_o | output | 1 | Serial clock, data sampled on rising edge |
| latch_o | output | 1 | Head latch pulse |
| stb_o | output | 4 | Strobe group outputs |
| line_done_o | output | 1 | One-cycle pulse when the last strobe ends |

## Verification
The assertions assume three things about the inputs:
- `stb_pol_i` is held constant while a line's strobes are in flight.
- `start_i` is a short pulse.
- A word offered on `valid_i` stays put until it is taken.

The stimulus changes polarity and the width and gap settings only between lines, after the done pulse. It offers each word with `valid_i` held until the handshake completes. It drives `valid_i` while the block is idle only in the test that checks such words are ignored.

// File: rtl/tph_pkg.sv
package tph_pkg;
  localparam int N_STB = 4;

  typedef enum logic [2:0] {
    SH_IDLE, SH_LOAD, SH_LO, SH_HI, SH_WAIT, SH_LATCH
  } sh_state_e;

  typedef enum logic [1:0] {
    SQ_IDLE, SQ_ON, SQ_GAP
  } sq_state_e;
endpackage

// File: rtl/tph_period_gate.sv
module tph_period_gate #(
  parameter int LINE_CYC = 120000
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic start_i,
  input  logic idle_i,
  output logic launch_o
);
  localparam int PC_W = $clog2(LINE_CYC + 1);
  localparam logic [PC_W-1:0] PC_LOAD = PC_W'(LINE_CYC - 1);

  logic            pend_q;
  logic [PC_W-1:0] per_cnt_q;

  assign launch_o = pend_q && (per_cnt_q == '0) && idle_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      pend_q    <= 1'b0;
      per_cnt_q <= '0;
    end else if (launch_o) begin
      pend_q    <= start_i;
      per_cnt_q <= PC_LOAD;
    end else begin
      if (start_i) pend_q <= 1'b1;
      if (per_cnt_q != '0) per_cnt_q <= per_cnt_q - 1'b1;
    end
  end

  // a launch always leaves a full period before the next one
  p_period_reload_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    launch_o |=> (per_cnt_q == PC_LOAD) && !launch_o);
endmodule

// File: rtl/tph_dot_shifter.sv
module tph_dot_shifter
  import tph_pkg::*;
#(
  parameter int WORD_W    = 8,
  parameter int WORDS     = 216,
  parameter int SCLK_HALF = 3,
  parameter int LATCH_W   = 4
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              launch_i,
  input  logic [WORD_W-1:0] data_i,
  input  logic              valid_i,
  input  logic              seq_busy_i,
  output logic              ready_o,
  output logic              idle_o,
  output logic              sdata_o,
  output logic              sclk_o,
  output logic              latch_o,
  output logic              fire_o
);
  localparam int DIV_W = $clog2(SCLK_HALF + 1);
  localparam int BIT_W = $clog2(WORD_W + 1);
  localparam int WRD_W = $clog2(WORDS + 1);
  localparam int LAT_W = $clog2(LATCH_W + 1);
  localparam logic [DIV_W-1:0] DIV_LAST = DIV_W'(SCLK_HALF - 1);
  localparam logic [BIT_W-1:0] BIT_LAST = BIT_W'(WORD_W - 1);
  localparam logic [WRD_W-1:0] WRD_LAST = WRD_W'(WORDS - 1);
  localparam logic [LAT_W-1:0] LAT_LAST = LAT_W'(LATCH_W - 1);

  sh_state_e         st_q;
  logic [WORD_W-1:0] sreg_q;
  logic [DIV_W-1:0]  div_q;
  logic [BIT_W-1:0]  bit_q;
  logic [WRD_W-1:0]  wrd_q;
  logic [LAT_W-1:0]  lat_q;

  assign ready_o = (st_q == SH_LOAD);
  assign idle_o  = (st_q == SH_IDLE);
  assign sclk_o  = (st_q == SH_HI);
  assign latch_o = (st_q == SH_LATCH);
  assign sdata_o = sreg_q[WORD_W-1];
  assign fire_o  = (st_q == SH_LATCH) && (lat_q == LAT_LAST);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q   <= SH_IDLE;
      sreg_q <= '0;
      div_q  <= '0;
      bit_q  <= '0;
      wrd_q  <= '0;
      lat_q  <= '0;
    end else begin
      unique case (st_q)
        SH_IDLE: if (launch_i) begin
          st_q  <= SH_LOAD;
          wrd_q <= '0;
        end
        SH_LOAD: if (valid_i) begin
          sreg_q <= data_i;
          bit_q  <= '0;
          div_q  <= '0;
          st_q   <= SH_LO;
        end
        SH_LO: if (div_q == DIV_LAST) begin
          div_q <= '0;
          st_q  <= SH_HI;
        end else begin
          div_q <= div_q + 1'b1;
        end
        SH_HI: if (div_q == DIV_LAST) begin
          div_q <= '0;
          if (bit_q == BIT_LAST) begin
            if (wrd_q == WRD_LAST) begin
              st_q <= SH_WAIT;
            end else begin
              wrd_q <= wrd_q + 1'b1;
              st_q  <= SH_LOAD;
            end
          end else begin
            bit_q  <= bit_q + 1'b1;
            sreg_q <= sreg_q << 1;
            st_q   <= SH_LO;
          end
        end else begin
          div_q <= div_q + 1'b1;
        end
        // hold latch until previous line's strobes are over
        SH_WAIT: if (!seq_busy_i) begin
          lat_q <= '0;
          st_q  <= SH_LATCH;
        end
        SH_LATCH: if (lat_q == LAT_LAST) begin
          st_q <= SH_IDLE;
        end else begin
          lat_q <= lat_q + 1'b1;
        end
        default: st_q <= SH_IDLE;
      endcase
    end
  end

  p_sdata_stable_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    sclk_o |-> $stable(sdata_o));

  p_latch_after_stb_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    latch_o |-> !seq_busy_i);
endmodule

// File: rtl/tph_strobe_seq.sv
module tph_strobe_seq
  import tph_pkg::*;
#(
  parameter int TICK_DIV = 12,
  parameter int CNT_W    = 12
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             fire_i,
  input  logic [CNT_W-1:0] on_width_i,
  input  logic [CNT_W-1:0] off_gap_i,
  output logic             busy_o,
  output logic [N_STB-1:0] act_o,
  output logic             done_o
);
  localparam int PH_W  = $clog2(N_STB);
  localparam int PRE_W = $clog2(TICK_DIV + 1);
  localparam logic [PH_W-1:0]  PH_LAST  = PH_W'(N_STB - 1);
  localparam logic [PRE_W-1:0] PRE_LAST = PRE_W'(TICK_DIV - 1);

  sq_state_e        st_q;
  logic [PH_W-1:0]  ph_q;
  logic [PRE_W-1:0] pre_q;
  logic [CNT_W-1:0] tcnt_q;
  logic [CNT_W-1:0] on_q;
  logic [CNT_W-1:0] off_q;
  logic             tick_end;
  logic [CNT_W-1:0] lim;

  assign busy_o   = (st_q != SQ_IDLE);
  assign tick_end = (pre_q == PRE_LAST);
  assign lim      = (st_q == SQ_ON) ? on_q : off_q;

  for (genvar g = 0; g < N_STB; g++) begin : g_act
    assign act_o[g] = (st_q == SQ_ON) && (ph_q == PH_W'(g));
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q   <= SQ_IDLE;
      ph_q   <= '0;
      pre_q  <= '0;
      tcnt_q <= '0;
      on_q   <= '0;
      off_q  <= '0;
      done_o <= 1'b0;
    end else begin
      done_o <= 1'b0;
      unique case (st_q)
        SQ_IDLE: if (fire_i) begin
          on_q   <= (on_width_i == '0) ? CNT_W'(1) : on_width_i;
          off_q  <= off_gap_i;
          ph_q   <= '0;
          pre_q  <= '0;
          tcnt_q <= '0;
          st_q   <= SQ_ON;
        end
        SQ_ON, SQ_GAP: if (tick_end) begin
          pre_q <= '0;
          if (tcnt_q == lim - 1'b1) begin
            tcnt_q <= '0;
            if (st_q == SQ_GAP) begin
              ph_q <= ph_q + 1'b1;
              st_q <= SQ_ON;
            end else if (ph_q == PH_LAST) begin
              st_q   <= SQ_IDLE;
              done_o <= 1'b1;
            end else if (off_q == '0) begin
              ph_q <= ph_q + 1'b1;
            end else begin
              st_q <= SQ_GAP;
            end
          end else begin
            tcnt_q <= tcnt_q + 1'b1;
          end
        end else begin
          pre_q <= pre_q + 1'b1;
        end
        default: st_q <= SQ_IDLE;
      endcase
    end
  end

  p_one_strobe_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0(act_o));

  p_done_single_r11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> !done_o);

  p_done_on_fall_r11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |-> ($past(act_o[N_STB-1]) && !act_o[N_STB-1]));

  p_first_phase_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(busy_o) |-> act_o[0]);
endmodule

// File: rtl/tph_line_ctrl.sv
module tph_line_ctrl
  import tph_pkg::*;
#(
  parameter int DOTS       = 1728,
  parameter int WORD_W     = 8,
  parameter int SCLK_HALF  = 3,
  parameter int TICK_DIV   = 12,
  parameter int LINE_TICKS = 10000,
  parameter int LATCH_W    = 4,
  parameter int CNT_W      = 12
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              start_i,
  input  logic [WORD_W-1:0] data_i,
  input  logic              valid_i,
  output logic              ready_o,
  input  logic              stb_pol_i,
  input  logic [CNT_W-1:0]  on_width_i,
  input  logic [CNT_W-1:0]  off_gap_i,
  output logic              sdata_o,
  output logic              sclk_o,
  output logic              latch_o,
  output logic [3:0]        stb_o,
  output logic              line_done_o
);
  localparam int WORDS    = DOTS / WORD_W;
  localparam int LINE_CYC = LINE_TICKS * TICK_DIV;

  logic             launch;
  logic             sh_idle;
  logic             fire;
  logic             seq_busy;
  logic [N_STB-1:0] act;

  tph_period_gate #(.LINE_CYC(LINE_CYC)) u_gate (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .start_i  (start_i),
    .idle_i   (sh_idle),
    .launch_o (launch)
  );

  tph_dot_shifter #(
    .WORD_W    (WORD_W),
    .WORDS     (WORDS),
    .SCLK_HALF (SCLK_HALF),
    .LATCH_W   (LATCH_W)
  ) u_shift (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .launch_i   (launch),
    .data_i     (data_i),
    .valid_i    (valid_i),
    .seq_busy_i (seq_busy),
    .ready_o    (ready_o),
    .idle_o     (sh_idle),
    .sdata_o    (sdata_o),
    .sclk_o     (sclk_o),
    .latch_o    (latch_o),
    .fire_o     (fire)
  );

  tph_strobe_seq #(.TICK_DIV(TICK_DIV), .CNT_W(CNT_W)) u_seq (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .fire_i     (fire),
    .on_width_i (on_width_i),
    .off_gap_i  (off_gap_i),
    .busy_o     (seq_busy),
    .act_o      (act),
    .done_o     (line_done_o)
  );

  for (genvar g = 0; g < N_STB; g++) begin : g_pol
    assign stb_o[g] = act[g] ~^ stb_pol_i;
  end

  p_idle_level_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !seq_busy |-> (stb_o == {N_STB{~stb_pol_i}}));
endmodule

// File: tb/tb_tph_line_ctrl.sv
module tb_tph_line_ctrl;
  localparam int CLK_PERIOD = 10;
  localparam int DOTS = 8, WORD_W = 4, SCLK_HALF = 1, TICK_DIV = 2;
  localparam int LINE_TICKS = 40, LATCH_W = 2, CNT_W = 12;
  localparam int LINE_CYC = LINE_TICKS * TICK_DIV;
  localparam int NV = 5;
  localparam logic [7:0] V_DAT [NV] = '{8'hA5, 8'h3C, 8'hFF, 8'h00, 8'h96};
  localparam int V_ON  [NV] = '{1, 3, 0, 2, 4};
  localparam int V_OFF [NV] = '{1, 0, 2, 5, 1};
  localparam int V_POL [NV] = '{1, 0, 1, 0, 1};

  logic clk = 0, rst_ni = 0, start_i = 0, valid_i = 0, stb_pol_i = 1;
  logic [WORD_W-1:0] data_i = '0;
  logic [CNT_W-1:0] on_width_i = '0, off_gap_i = '0;
  logic ready_o, sdata_o, sclk_o, latch_o, line_done_o;
  logic [3:0] stb_o;

  int checks = 0, errors = 0, cyc = 0;
  // monitor state
  logic [7:0] cap = '0;
  int nb = 0, nl = 0, nsl = 0, cur = 0, nd = 0, llen = 0, gapc = 0, expn = 0;
  int ord_bad = 0, lat_bad = 0, done_bad = 0;
  bit armed = 0;
  logic ps = 0, pl = 0, pd = 0;
  logic [3:0] pa = '0;
  int run [4];
  logic [7:0] rec_bits [16];
  int rec_nb [16], rec_ll [16], rec_lt [16], s3_fall [16];
  int on_len [16][4], gap_len [16][4];

  tph_line_ctrl #(
    .DOTS(DOTS), .WORD_W(WORD_W), .SCLK_HALF(SCLK_HALF), .TICK_DIV(TICK_DIV),
    .LINE_TICKS(LINE_TICKS), .LATCH_W(LATCH_W), .CNT_W(CNT_W)
  ) dut (
    .clk_i(clk), .rst_ni(rst_ni), .start_i(start_i), .data_i(data_i),
    .valid_i(valid_i), .ready_o(ready_o), .stb_pol_i(stb_pol_i),
    .on_width_i(on_width_i), .off_gap_i(off_gap_i), .sdata_o(sdata_o),
    .sclk_o(sclk_o), .latch_o(latch_o), .stb_o(stb_o), .line_done_o(line_done_o)
  );

  always #(CLK_PERIOD / 2) clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  always @(negedge clk) begin
    logic [3:0] a;
    a = stb_pol_i ? stb_o : ~stb_o;
    if (rst_ni) begin
      if (sclk_o && !ps) begin
        cap = {cap[6:0], sdata_o};
        nb++;
      end
      if (latch_o && !pl) begin
        if (nb != DOTS || a != 0) lat_bad++;
        rec_bits[nl] = cap; rec_nb[nl] = nb; rec_lt[nl] = cyc;
        nb = 0; llen = 0; armed = 1;
      end
      if (latch_o) llen++;
      if (!latch_o && pl) begin
        rec_ll[nl] = llen;
        nl++;
      end
      for (int i = 0; i < 4; i++)
        if (pa[i] && !a[i]) begin
          on_len[cur][i] = run[i]; run[i] = 0; gapc = 0;
          if (i == 3) s3_fall[cur] = cyc;
        end
      for (int i = 0; i < 4; i++)
        if (a[i] && !pa[i]) begin
          if (i != expn) ord_bad++;
          expn = (i + 1) % 4;
          if (i == 0) begin
            if (!armed || latch_o) ord_bad++;
            armed = 0; cur = nsl; nsl++;
          end else gap_len[cur][i] = gapc;
        end
      for (int i = 0; i < 4; i++) if (a[i]) run[i]++;
      if (a == 0) gapc++;
      if ($countones(a) > 1) ord_bad++;
      if (line_done_o) begin
        nd++;
        if (!(pa[3] && !a[3]) || pd) done_bad++;
      end
    end
    ps = sclk_o; pl = latch_o; pa = a; pd = line_done_o;
  end

  task automatic feed_line(input logic [7:0] dat, output int t0);
    @(negedge clk) start_i = 1;
    @(negedge clk) start_i = 0;
    t0 = -1;
    for (int w = 0; w < 2; w++) begin
      data_i = (w == 0) ? dat[7:4] : dat[3:0];
      valid_i = 1;
      while (!ready_o) @(negedge clk);
      if (w == 0) t0 = cyc;
      @(negedge clk) valid_i = 0;
    end
  endtask

  task automatic wait_done(input int target);
    while (nd < target) @(negedge clk);
    @(negedge clk);
  endtask

  task automatic check_line(input int k, input logic [7:0] dat, input int on, input int off);
    int w;
    w = ((on == 0) ? 1 : on) * TICK_DIV;
    chk(rec_bits[k] == dat, "R3 bits", int'(rec_bits[k]), int'(dat));
    chk(rec_nb[k] == DOTS, "R3 clock count", rec_nb[k], DOTS);
    chk(rec_ll[k] == LATCH_W, "R4 latch width", rec_ll[k], LATCH_W);
    for (int i = 0; i < 4; i++) chk(on_len[k][i] == w, "R6 on width", on_len[k][i], w);
    for (int i = 1; i < 4; i++)
      chk(gap_len[k][i] == off * TICK_DIV, "R7 gap", gap_len[k][i], off * TICK_DIV);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    errors++; checks++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    int ta, tb;
    repeat (3) @(negedge clk);
    // R1 reset state
    chk(stb_o == 4'h0 && !latch_o && !sclk_o && !line_done_o && !ready_o,
        "R1 reset outputs", int'({stb_o, latch_o, sclk_o, line_done_o, ready_o}), 0);
    rst_ni = 1;
    // R2 words offered while idle are ignored
    data_i = 4'hF; valid_i = 1;
    repeat (6) @(negedge clk);
    chk(!ready_o && nb == 0 && !sclk_o, "R2 idle valid ignored", nb, 0);
    valid_i = 0;

    for (int k = 0; k < NV; k++) begin
      on_width_i = CNT_W'(V_ON[k]);
      off_gap_i  = CNT_W'(V_OFF[k]);
      stb_pol_i  = V_POL[k][0];
      feed_line(V_DAT[k], ta);
      wait_done(k + 1);
      check_line(k, V_DAT[k], V_ON[k], V_OFF[k]);
      chk(stb_o == (V_POL[k][0] ? 4'h0 : 4'hF), "R8 idle level", int'(stb_o),
          V_POL[k][0] ? 0 : 15);
    end

    // R9 / R10: second line shifts while the first one heats
    on_width_i = 15; off_gap_i = 2; stb_pol_i = 1;
    repeat (LINE_CYC) @(negedge clk);
    feed_line(8'hC3, ta);
    feed_line(8'h5A, tb);
    wait_done(NV + 2);
    chk(tb - ta == LINE_CYC, "R9 start held to period", tb - ta, LINE_CYC);
    chk(tb < s3_fall[NV], "R10 shift during strobes", tb, s3_fall[NV]);
    chk(rec_lt[NV + 1] > s3_fall[NV], "R10 latch after STB3", rec_lt[NV + 1], s3_fall[NV] + 1);
    check_line(NV, 8'hC3, 15, 2);
    check_line(NV + 1, 8'h5A, 15, 2);

    chk(ord_bad == 0, "R5 order/overlap", ord_bad, 0);
    chk(lat_bad == 0, "R4 latch placement", lat_bad, 0);
    chk(done_bad == 0, "R11 done pulse", done_bad, 0);
    chk(nd == NV + 2, "R11 done count", nd, NV + 2);
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule